// File: doc/BRIEF.md
# Synchronous DRAM Command Decoder with Bank State Tracking

This block watches the control pins of a two-bank synchronous DRAM on every rising clock edge. It turns them into a command code and keeps a record of which bank has a row open. With each command it reports the target bank, the row and column addresses, and the meaning of address bit 10. Bit 10 requests auto precharge on a column access. On a precharge it selects both banks.

The block is meant to sit beside a memory model or a controller as a protocol monitor. It raises an error flag when a command is illegal for the current bank state. It also raises the flag when a command arrives too early after a refresh. An illegal command is still reported, but it does not change the tracked bank state. The only timing rule tracked is the row-cycle window after an auto refresh or after leaving self refresh. Its length is set by the parameter `TRC_CYC`.

All outputs are registered. A command sampled at one rising edge appears on the outputs just after that same edge.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With the chip-select input high, the command is reported as no-operation (code 0). No bank state changes and no error is raised, whatever the other pins carry.
- R2: RAS low with CAS and WE high is an activate (code 1). It opens the bank chosen by the bank-select input (0 selects bank A, shown on bank_open_o[0]; 1 selects bank B, shown on bank_open_o[1]). row_o takes A0..A10 on every decoded activate.
- R3: RAS high with CAS low is a read (code 2) when WE is high and a write (code 3) when WE is low. col_o takes A0..A7, and auto_pre_o equals A10.
- R4: A legal read or write with A10 high closes the target bank. With A10 low, the bank stays open.
- R5: RAS and WE low with CAS high is a precharge (code 4). With A10 high, both banks close and pre_all_o is 1. With A10 low, only the bank chosen by the bank-select input closes.
- R6: RAS and CAS low with WE high is an auto refresh (code 5) when CKE is high and a self-refresh entry (code 6) when CKE is low. While in self refresh, every pin except CKE is ignored and no-operation is reported. The first edge with CKE high ends self refresh.
- R7: RAS, CAS and WE all low is a mode register set (code 7). RAS and CAS high with WE low decodes as burst stop (code 8) and changes no bank state.
- R8: An auto refresh, self-refresh entry or mode register set while any bank is open raises err_o and changes no state.
- R9: A read or write to a closed bank, or an activate to an open bank, raises err_o and leaves the bank state unchanged.
- R10: After a legal auto refresh at edge k, or a self-refresh exit at edge k, an activate, read, write, auto refresh or self-refresh entry at edges k+1 .. k+TRC_CYC-1 raises err_o and is ignored. At edge k+TRC_CYC it is legal again.
- R11: During reset, all outputs are zero: command no-operation, no bank open, no error. Each output reflects the pins sampled at the most recent rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pins sampled on rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke_i | input | 1 | Clock enable pin |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | 1 | Bank select |
| addr_i | input | 11 | Address lines A0..A10 |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 1 | Target bank of activate, read, write or precharge |
| row_o | output | 11 | Row from the last activate |
| col_o | output | 8 | Column from the last read or write |
| auto_pre_o | output | 1 | Read or write carried an auto-precharge request |
| pre_all_o | output | 1 | Precharge addressed both banks |
| bank_open_o | output | 2 | Per-bank open flag |
| err_o | output | 1 | Command illegal for current state |

## Verification
A wrong bank flag shows up on bank_open_o just after the edge where it goes wrong. At the next column access or activate to that bank, it also shows up as a spurious or missing err_o. A stale or misloaded row-cycle counter shows as an error flag one edge too early or too late, at the boundary of the refresh window. A self-refresh flag stuck set shows on the next edge: commands keep decoding as no-operation after CKE returns high.

// File: rtl/cmd_trk_pkg.sv
package cmd_trk_pkg;

    typedef enum logic [3:0] {
        CMD_NOP   = 4'd0,
        CMD_ACT   = 4'd1,
        CMD_READ  = 4'd2,
        CMD_WRITE = 4'd3,
        CMD_PRE   = 4'd4,
        CMD_REF   = 4'd5,
        CMD_SREF  = 4'd6,
        CMD_MRS   = 4'd7,
        CMD_BST   = 4'd8
    } cmd_e;

endpackage

// File: rtl/cmd_trk_decode.sv
module cmd_trk_decode
    import cmd_trk_pkg::*;
(
    input  logic cke_i,
    input  logic cs_n_i,
    input  logic ras_n_i,
    input  logic cas_n_i,
    input  logic we_n_i,
    output cmd_e cmd_o
);

    // Pin triple {ras, cas, we}, active low; chip select masks everything.
    always_comb begin
        cmd_o = CMD_NOP;
        if (!cs_n_i) begin
            unique case ({ras_n_i, cas_n_i, we_n_i})
                3'b011:  cmd_o = CMD_ACT;
                3'b101:  cmd_o = CMD_READ;
                3'b100:  cmd_o = CMD_WRITE;
                3'b010:  cmd_o = CMD_PRE;
                3'b001:  cmd_o = cke_i ? CMD_REF : CMD_SREF;
                3'b000:  cmd_o = CMD_MRS;
                3'b110:  cmd_o = CMD_BST;
                default: cmd_o = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/cmd_trk_bank.sv
module cmd_trk_bank (
    input  logic clk,
    input  logic rst_n,
    input  logic open_i,
    input  logic close_i,
    output logic is_open_o
);

    logic open_d, open_q;

    always_comb begin
        open_d = open_q;
        if (close_i) open_d = 1'b0;
        if (open_i)  open_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) open_q <= 1'b0;
        else        open_q <= open_d;
    end

    assign is_open_o = open_q;

endmodule

// File: rtl/cmd_trk_trc.sv
module cmd_trk_trc #(
    parameter int TRC_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    localparam int CW = (TRC_CYC < 2) ? 1 : $clog2(TRC_CYC);
    localparam logic [CW-1:0] LOAD = CW'(TRC_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)         cnt_d = LOAD;
        else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
    import cmd_trk_pkg::*;
#(
    parameter int NBANK   = 2,
    parameter int ROW_W   = 11,
    parameter int COL_W   = 8,
    parameter int AP_BIT  = 10,
    parameter int TRC_CYC = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cke_i,
    input  logic                      cs_n_i,
    input  logic                      ras_n_i,
    input  logic                      cas_n_i,
    input  logic                      we_n_i,
    input  logic [$clog2(NBANK)-1:0]  ba_i,
    input  logic [ROW_W-1:0]          addr_i,
    output logic [3:0]                cmd_o,
    output logic [$clog2(NBANK)-1:0]  bank_o,
    output logic [ROW_W-1:0]          row_o,
    output logic [COL_W-1:0]          col_o,
    output logic                      auto_pre_o,
    output logic                      pre_all_o,
    output logic [NBANK-1:0]          bank_open_o,
    output logic                      err_o
);

    localparam int BA_W = $clog2(NBANK);

    typedef struct packed {
        cmd_e             cmd;
        logic [BA_W-1:0]  bank;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             ap;
        logic             pa;
        logic             err;
        logic             sr;
    } state_t;

    state_t st_d, st_q;

    cmd_e             dec_cmd;
    cmd_e             eff_cmd;
    logic             trc_busy;
    logic             trc_start;
    logic             sr_exit;
    logic             a10;
    logic             any_open;
    logic             tgt_open;
    logic             bad;
    logic [NBANK-1:0] open_q;
    logic [NBANK-1:0] set_b;
    logic [NBANK-1:0] clr_b;

    cmd_trk_decode u_dec (
        .cke_i   (cke_i),
        .cs_n_i  (cs_n_i),
        .ras_n_i (ras_n_i),
        .cas_n_i (cas_n_i),
        .we_n_i  (we_n_i),
        .cmd_o   (dec_cmd)
    );

    cmd_trk_trc #(.TRC_CYC(TRC_CYC)) u_trc (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (trc_start),
        .busy_o  (trc_busy)
    );

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            cmd_trk_bank u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .open_i    (set_b[b]),
                .close_i   (clr_b[b]),
                .is_open_o (open_q[b])
            );
        end
    endgenerate

    // Legality of the command against bank state and the row-cycle window.
    always_comb begin
        a10      = addr_i[AP_BIT];
        sr_exit  = st_q.sr && cke_i;
        eff_cmd  = st_q.sr ? CMD_NOP : dec_cmd;
        any_open = |open_q;
        tgt_open = open_q[ba_i];
        unique case (eff_cmd)
            CMD_ACT:              bad = tgt_open || trc_busy;
            CMD_READ, CMD_WRITE:  bad = !tgt_open || trc_busy;
            CMD_REF, CMD_SREF:    bad = any_open || trc_busy;
            CMD_MRS:              bad = any_open;
            default:              bad = 1'b0;
        endcase
        trc_start = ((eff_cmd == CMD_REF) && !bad) || sr_exit;
    end

    // Per-bank open and close requests.
    always_comb begin
        for (int b = 0; b < NBANK; b++) begin
            set_b[b] = !bad && (eff_cmd == CMD_ACT) && (ba_i == BA_W'(b));
            clr_b[b] = !bad && (
                ((eff_cmd == CMD_PRE) && (a10 || (ba_i == BA_W'(b)))) ||
                (((eff_cmd == CMD_READ) || (eff_cmd == CMD_WRITE)) &&
                 a10 && (ba_i == BA_W'(b))));
        end
    end

    // Next value of every reported field.
    always_comb begin
        st_d      = st_q;
        st_d.cmd  = eff_cmd;
        st_d.err  = bad;
        st_d.ap   = 1'b0;
        st_d.pa   = 1'b0;
        st_d.bank = '0;
        unique case (eff_cmd)
            CMD_ACT: begin
                st_d.bank = ba_i;
                st_d.row  = addr_i;
            end
            CMD_READ, CMD_WRITE: begin
                st_d.bank = ba_i;
                st_d.col  = addr_i[COL_W-1:0];
                st_d.ap   = a10;
            end
            CMD_PRE: begin
                st_d.bank = ba_i;
                st_d.pa   = a10;
            end
            default: ;
        endcase
        if (sr_exit)
            st_d.sr = 1'b0;
        else if ((eff_cmd == CMD_SREF) && !bad)
            st_d.sr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cmd: CMD_NOP, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_o       = st_q.cmd;
    assign bank_o      = st_q.bank;
    assign row_o       = st_q.row;
    assign col_o       = st_q.col;
    assign auto_pre_o  = st_q.ap;
    assign pre_all_o   = st_q.pa;
    assign err_o       = st_q.err;
    assign bank_open_o = open_q;

endmodule

// File: rtl/cmd_trk_chk.sv
module cmd_trk_chk
    import cmd_trk_pkg::*;
#(
    parameter int NBANK = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       cmd_o,
    input logic             err_o,
    input logic             auto_pre_o,
    input logic             pre_all_o,
    input logic [NBANK-1:0] bank_open_o
);

    AST_NOP_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_NOP) |-> !err_o);  // R1

    AST_ERR_KEEPS_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $stable(bank_open_o));  // R9

    AST_AP_ON_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
        auto_pre_o |-> ((cmd_o == CMD_READ) || (cmd_o == CMD_WRITE)));  // R3

    AST_PREALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_all_o && !err_o) |-> (bank_open_o == '0));  // R5

    AST_REFRESH_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (((cmd_o == CMD_REF) || (cmd_o == CMD_SREF) || (cmd_o == CMD_MRS)) && !err_o)
        |-> (bank_open_o == '0));  // R8

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_b
            AST_OPEN_BY_ACT: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(bank_open_o[b]) |-> ((cmd_o == CMD_ACT) && !err_o));  // R2

            AST_CLOSE_BY_PRE: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(bank_open_o[b]) |-> ((cmd_o == CMD_PRE) ||
                    (((cmd_o == CMD_READ) || (cmd_o == CMD_WRITE)) && auto_pre_o)));  // R4
        end
    endgenerate

endmodule

bind sdram_cmd_tracker cmd_trk_chk #(.NBANK(NBANK)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_o       (cmd_o),
    .err_o       (err_o),
    .auto_pre_o  (auto_pre_o),
    .pre_all_o   (pre_all_o),
    .bank_open_o (bank_open_o)
);

// File: tb/sdram_cmd_tracker_bench.sv
module sdram_cmd_tracker_bench;

    localparam int TRC = 6;

    localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4,
                   C_REF = 5, C_SREF = 6, C_MRS = 7, C_BST = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic        ba = 1'b0;
    logic [10:0] addr = '0;
    logic [3:0]  cmd;
    logic        bank;
    logic [10:0] row;
    logic [7:0]  col;
    logic        ap, pa, err;
    logic [1:0]  open;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    sdram_cmd_tracker #(.TRC_CYC(TRC)) u_sdram_cmd_tracker (
        .clk(clk), .rst_n(rst_n), .cke_i(cke), .cs_n_i(cs_n), .ras_n_i(ras_n),
        .cas_n_i(cas_n), .we_n_i(we_n), .ba_i(ba), .addr_i(addr),
        .cmd_o(cmd), .bank_o(bank), .row_o(row), .col_o(col),
        .auto_pre_o(ap), .pre_all_o(pa), .bank_open_o(open), .err_o(err)
    );

    typedef struct {
        int         cmd;
        int         bank;
        int         row;
        int         col;
        bit         ap;
        bit         pa;
        bit [1:0]   open;
        bit         err;
        string      req;
    } exp_t;

    exp_t q[$];

    // Reference state built from the requirements.
    bit [1:0] m_open = 2'b00;
    int       m_trc  = 0;
    bit       m_sr   = 1'b0;
    int       m_row  = 0;
    int       m_col  = 0;

    task automatic drive(input bit c_cs, input bit c_ras, input bit c_cas,
                         input bit c_we, input bit c_cke, input bit c_ba,
                         input int c_a, input string req);
        exp_t e;
        int   c;
        bit   e_err;
        bit   start;
        bit   a10;
        @(negedge clk);
        cs_n = c_cs; ras_n = c_ras; cas_n = c_cas; we_n = c_we;
        cke = c_cke; ba = c_ba; addr = 11'(c_a);
        a10 = c_a[10];
        start = 1'b0;
        e_err = 1'b0;
        c = C_NOP;
        if (m_sr) begin
            if (c_cke) begin m_sr = 1'b0; start = 1'b1; end
        end else if (!c_cs) begin
            case ({c_ras, c_cas, c_we})
                3'b011: c = C_ACT;
                3'b101: c = C_RD;
                3'b100: c = C_WR;
                3'b010: c = C_PRE;
                3'b001: c = c_cke ? C_REF : C_SREF;
                3'b000: c = C_MRS;
                3'b110: c = C_BST;
                default: c = C_NOP;
            endcase
        end
        case (c)
            C_ACT:        e_err = m_open[c_ba] || (m_trc != 0);
            C_RD, C_WR:   e_err = !m_open[c_ba] || (m_trc != 0);
            C_REF, C_SREF: e_err = (m_open != 0) || (m_trc != 0);
            C_MRS:        e_err = (m_open != 0);
            default:      e_err = 1'b0;
        endcase
        e.ap = 1'b0; e.pa = 1'b0; e.bank = 0;
        if (c == C_ACT) begin
            m_row = c_a; e.bank = c_ba;
            if (!e_err) m_open[c_ba] = 1'b1;
        end
        if (c == C_RD || c == C_WR) begin
            m_col = c_a & 8'hFF; e.bank = c_ba; e.ap = a10;
            if (!e_err && a10) m_open[c_ba] = 1'b0;
        end
        if (c == C_PRE) begin
            e.bank = c_ba; e.pa = a10;
            if (a10) m_open = 2'b00; else m_open[c_ba] = 1'b0;
        end
        if (c == C_REF && !e_err) start = 1'b1;
        if (c == C_SREF && !e_err) m_sr = 1'b1;
        if (start) m_trc = TRC - 1;
        else if (m_trc > 0) m_trc--;
        e.cmd = c; e.row = m_row; e.col = m_col; e.open = m_open;
        e.err = e_err; e.req = req;
        q.push_back(e);
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) drive(1, 1, 1, 1, 1, 0, 0, "R11");
    endtask

    // Monitor: compares each registered result just after its edge.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (int'(cmd) != e.cmd || int'(bank) != e.bank || int'(row) != e.row ||
                int'(col) != e.col || ap != e.ap || pa != e.pa || open != e.open ||
                err != e.err) begin
                bad++;
                $display("FAIL %s: got cmd=%0d bank=%0d row=%h col=%h ap=%0b pa=%0b open=%b err=%0b exp cmd=%0d bank=%0d row=%h col=%h ap=%0b pa=%0b open=%b err=%0b",
                         e.req, cmd, bank, row, col, ap, pa, open, err,
                         e.cmd, e.bank, e.row, e.col, e.ap, e.pa, e.open, e.err);
            end
        end
    end

    initial begin
        #20000;
        bad++;
        total++;
        $display("FAIL watchdog: got running exp finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        total++;
        if (cmd !== 4'd0 || open !== 2'b00 || err !== 1'b0 || row !== '0 || col !== '0) begin
            bad++;
            $display("FAIL R11 reset: got cmd=%0d open=%b err=%0b exp cmd=0 open=00 err=0",
                     cmd, open, err);
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R1: chip select high masks an activate pattern
        drive(1, 0, 1, 1, 1, 0, 11'h123, "R1");
        // R2: activate bank A
        drive(0, 0, 1, 1, 1, 0, 11'h5A3, "R2");
        // R9: activate to an open bank, read of a closed bank
        drive(0, 0, 1, 1, 1, 0, 11'h011, "R9");
        drive(0, 1, 0, 1, 1, 1, 11'h022, "R9");
        // R2: activate bank B
        drive(0, 0, 1, 1, 1, 1, 11'h7FF, "R2");
        // R3: read, no auto precharge
        drive(0, 1, 0, 1, 1, 0, 11'h03C, "R3");
        // R4: write with auto precharge closes bank B
        drive(0, 1, 0, 0, 1, 1, 11'h4C5, "R4");
        // R8: refresh and mode set with bank A open
        drive(0, 0, 0, 1, 1, 0, 0, "R8");
        drive(0, 0, 0, 0, 1, 0, 11'h032, "R8");
        // R1: masked precharge-all leaves bank A open
        drive(1, 0, 1, 0, 1, 0, 11'h400, "R1");
        // R7: burst stop decodes without state change
        drive(0, 1, 1, 0, 1, 0, 0, "R7");
        // R5: single-bank precharge
        drive(0, 0, 1, 0, 1, 0, 11'h000, "R5");
        drive(0, 0, 1, 1, 1, 0, 11'h101, "R2");
        drive(0, 0, 1, 1, 1, 1, 11'h202, "R2");
        // R5: precharge both banks
        drive(0, 0, 1, 0, 1, 1, 11'h400, "R5");
        // R7: legal mode register set
        drive(0, 0, 0, 0, 1, 0, 11'h032, "R7");
        // R6: auto refresh, R10: window after it
        drive(0, 0, 0, 1, 1, 0, 0, "R6");
        drive(0, 0, 1, 1, 1, 0, 11'h0AA, "R10");
        nop(3);
        drive(0, 0, 1, 1, 1, 0, 11'h0AB, "R10");
        drive(0, 0, 1, 1, 1, 0, 11'h0AC, "R10");
        drive(0, 0, 1, 0, 1, 0, 11'h400, "R5");
        // R6: self refresh entry, pins ignored, exit
        drive(0, 0, 0, 1, 0, 0, 0, "R6");
        drive(0, 0, 1, 1, 0, 1, 11'h333, "R6");
        drive(0, 0, 0, 0, 0, 0, 0, "R6");
        drive(1, 1, 1, 1, 1, 0, 0, "R6");
        // R10: window after self-refresh exit
        drive(0, 0, 1, 1, 1, 1, 11'h044, "R10");
        nop(4);
        drive(0, 0, 0, 1, 1, 0, 0, "R10");
        drive(0, 0, 1, 1, 1, 1, 11'h055, "R10");
        drive(0, 1, 0, 1, 1, 1, 11'h4FE, "R4");
        nop(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule